// File: doc/BRIEF.md
# Tri-State Parallel Result Port

This block is the host-facing side of a converter. It keeps the most recent conversion word in a result register and puts it on a shared parallel bus when the host selects it. The core's busy flag governs the register. The register takes a new word only when busy drops, which marks the end of a conversion. A host that reads while a conversion is running therefore sees the previous result, and a host that reads after busy drops sees the new one.

Two selections act on the word on its way out, and neither adds a clock cycle. The first changes the output coding. The stored word is offset binary, and the port can emit it unchanged or as two's complement by inverting the sign bit. The second exchanges the two byte lanes. A host with an 8-bit bus can tie this input to an address line and fetch both halves of the word from the same eight pins. The bus is modelled as a resolved net with an output-enable flag beside it, and it stays undriven unless both active-low select strobes are asserted.

Top module: `result_port`

## Requirements
- R1: `pbus_oe` is 1 exactly when `cs_n` and `rd_n` are both 0.
- R2: While `cs_n` or `rd_n` is 1, every bit of `pbus` is high impedance (z).
- R3: With `lane_swap` = 0 and the bus enabled, `pbus[7:0]` carries bits 7..0 of the coded word and `pbus[15:8]` carries bits 15..8.
- R4: With `lane_swap` = 1 and the bus enabled, the lanes are exchanged: `pbus[15:8]` carries coded bits 7..0 and `pbus[7:0]` carries coded bits 15..8.
- R5: With `code_twos` = 0 the coded word equals the stored offset-binary word. With `code_twos` = 1 the coded word equals the stored word with bit 15 inverted.
- R6: The result register loads `conv_word` on a rising clock edge where `conv_busy` is sampled 0 and was sampled 1 on the previous edge. The new value is visible on the bus from that edge onward.
- R7: A change of `conv_word` at any other edge leaves the stored word unchanged. A read during a conversion (busy high) returns the previous result.
- R8: Synchronous active-high `rst` clears the result register to 0 and clears the remembered busy level. An enabled read after reset returns 16'h0000 with offset coding and 16'h8000 with two's complement.
- R9: A change of `lane_swap` or `code_twos` changes the driven bus value in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_busy | input | 1 | Conversion in progress; its fall loads the result |
| conv_word | input | 16 | Finished conversion word, offset binary |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| lane_swap | input | 1 | 1 exchanges the two byte lanes |
| code_twos | input | 1 | 1 selects two's-complement output |
| pbus | inout | 16 | Resolved parallel data bus |
| pbus_oe | output | 1 | 1 while the port drives `pbus` |

## Verification
If the stored word loads on the wrong busy edge, or loads while busy is still high, the next enabled read shows the wrong result, one edge after the load should or should not have happened. An error in the lane or sign-bit handling shows on the bus in the same cycle as the enabled read, because that path has no register. A fault in the enable path shows as a driven bus while a strobe is high, or as z during an enabled read. Random strobe, busy and word patterns make each of these faults reach the bus quickly.

// File: rtl/result_port_pkg.sv
package result_port_pkg;

    // Output coding applied to the stored offset-binary word
    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } code_e;

    // Host-side controls gathered for the output path
    typedef struct packed {
        logic  selected;   // both strobes asserted
        logic  swap;       // exchange byte lanes
        code_e code;       // output coding
    } host_ctl_t;

    // Build the control struct from raw pins
    function automatic host_ctl_t make_ctl(input logic cs_n, input logic rd_n,
                                           input logic swap, input logic twos);
        host_ctl_t c;
        c.selected = ~cs_n & ~rd_n;
        c.swap     = swap;
        c.code     = twos ? CODE_TWOS : CODE_OFFSET;
        return c;
    endfunction

endpackage

// File: rtl/rp_capture.sv
module rp_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [DATA_W-1:0] word_in,
    output logic [DATA_W-1:0] res_q
);
    logic busy_q;
    logic busy_fall;

    assign busy_fall = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            res_q  <= '0;
        end else begin
            busy_q <= busy;
            if (busy_fall) begin
                res_q <= word_in;
            end
        end
    end
endmodule

// File: rtl/rp_format.sv
module rp_format
    import result_port_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] res,
    input  host_ctl_t         ctl,
    output logic [DATA_W-1:0] word_out
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    logic [DATA_W-1:0] coded;

    always_comb begin
        coded = res;
        if (ctl.code == CODE_TWOS) begin
            coded[DATA_W-1] = ~res[DATA_W-1];
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign word_out[g*LANE_W +: LANE_W] = ctl.swap
            ? coded[(NUM_LANES-1-g)*LANE_W +: LANE_W]
            : coded[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/rp_drive.sv
module rp_drive
    import result_port_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  host_ctl_t         ctl,
    input  logic [DATA_W-1:0] word_in,
    output logic              oe,
    output logic [DATA_W-1:0] drive_word
);
    assign oe         = ctl.selected;
    assign drive_word = word_in;
endmodule

// File: rtl/result_port.sv
module result_port
    import result_port_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_busy,
    input  logic [DATA_W-1:0] conv_word,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              lane_swap,
    input  logic              code_twos,
    inout  wire  [DATA_W-1:0] pbus,
    output logic              pbus_oe
);
    host_ctl_t         ctl;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] fmt_word;
    logic [DATA_W-1:0] drive_word;

    assign ctl = make_ctl(cs_n, rd_n, lane_swap, code_twos);

    rp_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .busy    (conv_busy),
        .word_in (conv_word),
        .res_q   (res_q)
    );

    rp_format #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_format (
        .res      (res_q),
        .ctl      (ctl),
        .word_out (fmt_word)
    );

    rp_drive #(.DATA_W(DATA_W)) u_drive (
        .ctl        (ctl),
        .word_in    (fmt_word),
        .oe         (pbus_oe),
        .drive_word (drive_word)
    );

    assign pbus = pbus_oe ? drive_word : {DATA_W{1'bz}};
endmodule

// File: rtl/result_port_chk.sv
module result_port_chk #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_busy,
    input logic [DATA_W-1:0] conv_word,
    input logic              cs_n,
    input logic              rd_n,
    input logic              lane_swap,
    input logic              code_twos,
    input logic              pbus_oe,
    input logic [DATA_W-1:0] res_q,
    input logic [DATA_W-1:0] drive_word
);
    localparam int HI = DATA_W - 1;

    // R1 / R2: a high strobe forbids driving
    a_r2_cs_blocks: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !pbus_oe);
    a_r2_rd_blocks: assert property (@(posedge clk) disable iff (rst)
        rd_n |-> !pbus_oe);
    a_r1_enabled: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !rd_n) |-> pbus_oe);

    // R6: a busy fall loads the word presented at that edge
    a_r6_load: assert property (@(posedge clk) disable iff (rst)
        ($past(conv_busy) && !conv_busy) |=> (res_q == $past(conv_word)));

    // R7: no busy fall, no change of the stored word
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !($past(conv_busy) && !conv_busy) |=> $stable(res_q));

    // R3 / R5: unswapped sign bit position
    a_r5_sign_plain: assert property (@(posedge clk) disable iff (rst)
        (pbus_oe && !lane_swap) |-> (drive_word[HI] == (res_q[HI] ^ code_twos)));

    // R4 / R5: swapped sign bit lands at the top of the low lane
    a_r4_sign_swapped: assert property (@(posedge clk) disable iff (rst)
        (pbus_oe && lane_swap) |-> (drive_word[LANE_W-1] == (res_q[HI] ^ code_twos)));
endmodule

bind result_port result_port_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_busy  (conv_busy),
    .conv_word  (conv_word),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .lane_swap  (lane_swap),
    .code_twos  (code_twos),
    .pbus_oe    (pbus_oe),
    .res_q      (res_q),
    .drive_word (drive_word)
);

// File: tb/tb_result_port.sv
module tb_result_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_busy = 1'b0;
    logic [15:0] conv_word = '0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        lane_swap = 1'b0;
    logic        code_twos = 1'b0;
    wire  [15:0] pbus;
    logic        pbus_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench-side model of the stored word
    logic [15:0] m_res;
    logic        m_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_port dut (
        .clk(clk), .rst(rst), .conv_busy(conv_busy), .conv_word(conv_word),
        .cs_n(cs_n), .rd_n(rd_n), .lane_swap(lane_swap), .code_twos(code_twos),
        .pbus(pbus), .pbus_oe(pbus_oe)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_res  <= 16'h0000;
            m_busy <= 1'b0;
        end else begin
            if (m_busy && !conv_busy) m_res <= conv_word;
            m_busy <= conv_busy;
        end
    end

    function automatic logic [15:0] exp_bus(input logic [15:0] r, input logic cs,
                                            input logic rd, input logic sw, input logic tc);
        logic [15:0] c;
        if (cs || rd) return 16'hzzzz;
        c = r;
        c[15] = c[15] ^ tc;
        return sw ? {c[7:0], c[15:8]} : c;
    endfunction

    task automatic check(input string req);
        logic [15:0] e;
        logic        eo;
        e  = exp_bus(m_res, cs_n, rd_n, lane_swap, code_twos);
        eo = !cs_n && !rd_n;
        n_chk++;
        if (pbus !== e || pbus_oe !== eo) begin
            n_fail++;
            $display("FAIL %s bus=%h oe=%b expected bus=%h oe=%b", req, pbus, pbus_oe, e, eo);
        end
    endtask

    task automatic step(input logic b, input logic [15:0] w, input logic cs, input logic rd,
                        input logic sw, input logic tc, input string req);
        @(negedge clk);
        conv_busy = b; conv_word = w; cs_n = cs; rd_n = rd; lane_swap = sw; code_twos = tc;
        #(CLK_PERIOD/4);
        check(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        step(1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, "R2 cs high in reset");
        @(negedge clk); rst = 1'b0;
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R8 reset offset");
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, "R8 reset twos");
        step(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, "R2 rd high");
        step(1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, "R1 both high");
        // conversion of 0x1234
        step(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, "R7 read during conversion");
        step(1'b1, 16'hABCD, 1'b0, 1'b0, 1'b0, 1'b0, "R7 still previous");
        step(1'b0, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, "R6 fall presented");
        step(1'b0, 16'h5555, 1'b0, 1'b0, 1'b0, 1'b0, "R6 new result 1234");
        step(1'b0, 16'h9999, 1'b0, 1'b0, 1'b1, 1'b0, "R4 swapped lanes");
        step(1'b0, 16'h9999, 1'b0, 1'b0, 1'b0, 1'b0, "R3 plain lanes");
        step(1'b0, 16'h7777, 1'b0, 1'b0, 1'b0, 1'b1, "R5 twos plain");
        step(1'b0, 16'h7777, 1'b0, 1'b0, 1'b1, 1'b1, "R9 twos swapped same cycle");
        step(1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R7 idle word change");
        // 8-bit host style read of a high-sign word
        step(1'b1, 16'h80FE, 1'b0, 1'b1, 1'b0, 1'b0, "R2 busy no read");
        step(1'b0, 16'h80FE, 1'b0, 1'b1, 1'b0, 1'b0, "R2 fall no read");
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, "R3 low lane read");
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, "R4 high lane read");
        step(1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, "R5 high lane twos");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic b;
            b = ($urandom % 3) != 0 ? conv_busy : ~conv_busy;
            step(b, 16'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
                 1'($urandom), 1'($urandom), "R6 R9 random");
        end
        // reset mid-stream clears the stored word
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        step(1'b0, 16'h4321, 1'b0, 1'b0, 1'b0, 1'b1, "R8 reset again");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule